// File: doc/BRIEF.md
# Selectable Output Response Compactor

This block sits at the output of a circuit under test during self-test and reduces the whole stream of response words to one signature register. No response is stored. A test opens with a one-cycle `start` pulse. Every response word offered with `resp_valid` is then folded into the signature. When `NUM_RESP` words have been accepted, the block raises `done` for one cycle and sets `pass` from a comparison of the final signature against the golden value on `golden`.

Three compaction methods share the same datapath and handshake. Two of them are saturating counters: one adds up the 1 bits in each word, the other adds up the bit changes between consecutive words. The third is a multiple-input signature register. It uses a Galois-form shift whose feedback polynomial is taken from `taps`. The method is chosen by `mode` and latched at `start`, so the whole test uses one method.

Top module: `resp_compactor`

## Requirements
- R1: After reset, `signature` is 0, and `done` and `pass` are 0.
- R2: A `start` pulse clears `signature` and `pass` to 0 on the next edge. A response offered in the same cycle as `start` is not accepted.
- R3: Mode code 0 (ones count): each accepted word adds the number of 1 bits in that word to `signature`.
- R4: Mode code 1 (transition count): each accepted word adds the number of bit positions that differ from the previously accepted word. The first word after `start` only records the previous value and adds nothing.
- R5: Mode codes 2 and 3 (signature analysis): each accepted word sets `signature` to ({signature[SIG_W-2:0],0} XOR (taps if signature[SIG_W-1] is 1, else 0) XOR the zero-extended word).
- R6: In modes 0 and 1, `signature` stops at 2^SIG_W-1 instead of wrapping.
- R7: `done` is high for exactly one cycle, in the cycle after the edge that accepts the NUM_RESP-th word. After that, words are ignored and `signature` holds until the next `start`.
- R8: In the cycle `done` is high, `pass` equals (final signature == `golden`). `pass` then holds, regardless of `golden`, until the next `start`.
- R9: `mode` is sampled only at `start`. Changing it during a test has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a new test |
| resp_data | input | RESP_W | Response word from the circuit under test |
| resp_valid | input | 1 | `resp_data` is valid this cycle |
| mode | input | 2 | 0 ones, 1 transitions, 2/3 signature analysis |
| taps | input | SIG_W | Feedback polynomial for signature analysis |
| golden | input | SIG_W | Expected final signature |
| signature | output | SIG_W | Current signature |
| done | output | 1 | One-cycle end-of-test strobe |
| pass | output | 1 | Final signature matched `golden` |

## Verification
Every accepted word changes `signature` on the very next edge. The bench drives inputs on the falling edge and checks the running signature on the following falling edge, against a model updated for the same word. `done` and `pass` also appear one edge after the last word is accepted. The bench checks them at that falling edge, and one cycle later it checks that `done` has dropped and that `pass` and `signature` hold while stray words and a changed golden value are applied. The cleared state after `start` is checked one cycle after the pulse.

// File: rtl/rc_pkg.sv
// Package: shared types for the response compactor.
// Assumes: the mode encoding is fixed and known to the test controller.
package rc_pkg;
    typedef enum logic [1:0] {
        CMP_ONES  = 2'b00,
        CMP_TRANS = 2'b01,
        CMP_SIG   = 2'b10,
        CMP_SIG_B = 2'b11
    } cmp_mode_e;
endpackage

// File: rtl/rc_ctrl.sv
// Module: rc_ctrl
// Runs one test. Opens it on start, accepts up to NUM_RESP valid words,
// then pulses done. Assumes start is a single-cycle pulse.
module rc_ctrl #(
    parameter int NUM_RESP = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic resp_valid,
    output logic take,
    output logic first,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(NUM_RESP + 1);

    logic [CNT_W-1:0] cnt_q;

    // Accept words only while a test is running and not on a start cycle.
    always_comb begin
        take = busy && resp_valid && !start;
        last = take && (cnt_q == CNT_W'(NUM_RESP - 1));
    end

    // Sequence state: word count, busy, first-word flag, done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            busy  <= 1'b0;
            first <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            busy  <= 1'b1;
            first <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= last;
            if (take) begin
                cnt_q <= cnt_q + 1'b1;
                first <= 1'b0;
                if (last) begin
                    busy <= 1'b0;
                end
            end
        end
    end

    // R7: done lasts one cycle only.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: nothing is accepted once the test has finished.
    assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |-> !busy);
endmodule

// File: rtl/rc_count.sv
// Module: rc_count
// Next-value logic for the two counting modes: ones or bit transitions,
// with saturation. Holds the previous accepted word for transition mode.
// Assumes RESP_W <= SIG_W.
module rc_count #(
    parameter int RESP_W = 16,
    parameter int SIG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              first,
    input  logic              trans_mode,
    input  logic [RESP_W-1:0] resp,
    input  logic [SIG_W-1:0]  sig_in,
    output logic [SIG_W-1:0]  sig_next
);
    localparam int INC_W = $clog2(RESP_W + 1);

    logic [RESP_W-1:0] prev_q;
    logic [RESP_W-1:0] probe;
    logic [INC_W-1:0]  inc;
    logic [SIG_W:0]    sum;

    // Previous accepted word, used to count bit changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (take) begin
            prev_q <= resp;
        end
    end

    // Choose the vector to count, count its set bits, saturate the sum.
    always_comb begin
        probe = trans_mode ? (resp ^ prev_q) : resp;
        inc = '0;
        for (int i = 0; i < RESP_W; i++) begin
            inc = inc + INC_W'(probe[i]);
        end
        if (trans_mode && first) begin
            inc = '0;
        end
        sum = {1'b0, sig_in} + (SIG_W + 1)'(inc);
        sig_next = sum[SIG_W] ? {SIG_W{1'b1}} : sum[SIG_W-1:0];
    end

    // R4: the first word of a transition test adds nothing.
    assert_first_primes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && trans_mode && first) |-> (sig_next == sig_in));
endmodule

// File: rtl/rc_misr.sv
// Module: rc_misr
// Next-value logic of a Galois multiple-input signature register.
// Assumes taps holds steady during a test and RESP_W <= SIG_W.
module rc_misr #(
    parameter int RESP_W = 16,
    parameter int SIG_W  = 16
) (
    input  logic [RESP_W-1:0] resp,
    input  logic [SIG_W-1:0]  taps,
    input  logic [SIG_W-1:0]  sig_in,
    output logic [SIG_W-1:0]  sig_next
);
    logic [SIG_W-1:0] resp_ext;

    // Widen the response to the signature width.
    generate
        if (RESP_W < SIG_W) begin : g_pad
            assign resp_ext = {{(SIG_W - RESP_W){1'b0}}, resp};
        end else begin : g_same
            assign resp_ext = resp[SIG_W-1:0];
        end
    endgenerate

    // Shift left, apply feedback from the top bit, fold in the word.
    always_comb begin
        sig_next = {sig_in[SIG_W-2:0], 1'b0}
                 ^ (sig_in[SIG_W-1] ? taps : '0)
                 ^ resp_ext;
    end
endmodule

// File: rtl/resp_compactor.sv
// Module: resp_compactor (top)
// Folds response words into one signature using a method chosen at start,
// and compares the result with golden when the test ends.
// Assumes RESP_W <= SIG_W, SIG_W >= 2, and that start is a single-cycle pulse.
module resp_compactor
    import rc_pkg::*;
#(
    parameter int RESP_W   = 16,
    parameter int SIG_W    = 16,
    parameter int NUM_RESP = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RESP_W-1:0] resp_data,
    input  logic              resp_valid,
    input  logic [1:0]        mode,
    input  logic [SIG_W-1:0]  taps,
    input  logic [SIG_W-1:0]  golden,
    output logic [SIG_W-1:0]  signature,
    output logic              done,
    output logic              pass
);
    cmp_mode_e        mode_q;
    logic             take, first, last, busy;
    logic             count_mode, trans_mode;
    logic [SIG_W-1:0] sig_q, cnt_next, misr_next, sig_next;
    logic             pass_q;

    rc_ctrl #(.NUM_RESP(NUM_RESP)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .resp_valid (resp_valid),
        .take       (take),
        .first      (first),
        .last       (last),
        .busy       (busy),
        .done       (done)
    );

    rc_count #(.RESP_W(RESP_W), .SIG_W(SIG_W)) i_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .first      (first),
        .trans_mode (trans_mode),
        .resp       (resp_data),
        .sig_in     (sig_q),
        .sig_next   (cnt_next)
    );

    rc_misr #(.RESP_W(RESP_W), .SIG_W(SIG_W)) i_misr (
        .resp     (resp_data),
        .taps     (taps),
        .sig_in   (sig_q),
        .sig_next (misr_next)
    );

    // Decode the latched mode and pick the next signature.
    always_comb begin
        count_mode = (mode_q == CMP_ONES) || (mode_q == CMP_TRANS);
        trans_mode = (mode_q == CMP_TRANS);
        sig_next   = count_mode ? cnt_next : misr_next;
    end

    // Latch the mode once per test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= CMP_ONES;
        end else if (start) begin
            mode_q <= cmp_mode_e'(mode);
        end
    end

    // Signature register: cleared on start, updated on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else if (start) begin
            sig_q <= '0;
        end else if (take) begin
            sig_q <= sig_next;
        end
    end

    // Verdict: set with the last word, held until the next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
        end else if (start) begin
            pass_q <= 1'b0;
        end else if (last) begin
            pass_q <= (sig_next == golden);
        end
    end

    assign signature = sig_q;
    assign pass      = pass_q;

    // R2: start clears the signature.
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (sig_q == '0));
    // R6: a saturated counter stays saturated.
    assert_saturation_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && count_mode && (sig_q == {SIG_W{1'b1}})) |=> (sig_q == {SIG_W{1'b1}}));
    // R3: counting modes never decrease.
    assert_count_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && count_mode) |=> (sig_q >= $past(sig_q)));
    // R7: with no test running, the signature does not move.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(sig_q));
    // R8: the verdict changes only at start or at the end of a test.
    assert_pass_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !last) |=> $stable(pass_q));
    // R9: the mode stays fixed between starts.
    assert_mode_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(mode_q));
endmodule

// File: tb/test_resp_compactor.sv
module test_resp_compactor;
    localparam int SW = 8;
    localparam int RW = 8;
    localparam int NR = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          resp_valid = 1'b0;
    logic [RW-1:0] resp_data = '0;
    logic [1:0]    mode = 2'b00;
    logic [SW-1:0] taps = 8'h1D;
    logic [SW-1:0] golden = '0;
    logic [SW-1:0] signature;
    logic          done;
    logic          pass;

    int checks = 0;
    int fails = 0;

    resp_compactor #(.RESP_W(RW), .SIG_W(SW), .NUM_RESP(NR)) i_resp_compactor (
        .clk(clk), .rst_n(rst_n), .start(start), .resp_data(resp_data),
        .resp_valid(resp_valid), .mode(mode), .taps(taps), .golden(golden),
        .signature(signature), .done(done), .pass(pass)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pop(input logic [RW-1:0] v);
        int n = 0;
        for (int i = 0; i < RW; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [SW-1:0] step(input logic [1:0] m, input logic [SW-1:0] s,
                                           input logic [RW-1:0] p, input bit f,
                                           input logic [RW-1:0] d);
        int t;
        if (m[1]) return {s[SW-2:0], 1'b0} ^ (s[SW-1] ? taps : '0) ^ d;
        t = int'(s) + (m[0] ? (f ? 0 : pop(d ^ p)) : pop(d));
        return (t > 255) ? 8'hFF : t[SW-1:0];
    endfunction

    function automatic logic [RW-1:0] gen(input int kind, input int i);
        case (kind)
            1: return 8'hFF;
            2: return (i % 2 == 0) ? 8'h55 : 8'hAA;
            3: return 8'hA5;
            default: return RW'($urandom);
        endcase
    endfunction

    task automatic run(input logic [1:0] m, input int kind, input bit good, input bit chg);
        logic [SW-1:0] exp = '0;
        logic [RW-1:0] prev = '0;
        logic [RW-1:0] d;
        bit first = 1'b1;
        string rq;
        rq = m[1] ? "R5" : (m[0] ? "R4" : "R3");
        if (chg) rq = {rq, "/R9"};
        if (kind == 1 || kind == 2) rq = {rq, "/R6"};
        @(negedge clk);
        start = 1'b1; mode = m; resp_valid = 1'b1; resp_data = 8'hFF;
        @(negedge clk);
        start = 1'b0; resp_valid = 1'b0;
        check(signature == 0, "R2 clear", int'(signature), 0);
        check(pass == 1'b0, "R2 pass clear", int'(pass), 0);
        for (int i = 0; i < NR; i++) begin
            if ($urandom % 4 == 0) begin
                resp_valid = 1'b0;
                @(negedge clk);
            end
            d = gen(kind, i);
            resp_data = d; resp_valid = 1'b1;
            if (chg && i == NR / 2) mode = m ^ 2'b10;
            exp = step(m, exp, prev, first, d);
            prev = d; first = 1'b0;
            if (i == NR - 1) golden = good ? exp : (exp ^ 8'h01);
            @(negedge clk);
            resp_valid = 1'b0;
            check(signature == exp, rq, int'(signature), int'(exp));
            if (i < NR - 1) check(done == 1'b0, "R7 early done", int'(done), 0);
        end
        check(done == 1'b1, "R7 done", int'(done), 1);
        check(pass == good, "R8 verdict", int'(pass), int'(good));
        resp_valid = 1'b1; resp_data = RW'($urandom);
        @(negedge clk);
        resp_valid = 1'b0; golden = ~golden;
        check(done == 1'b0, "R7 single pulse", int'(done), 0);
        check(signature == exp, "R7 frozen", int'(signature), int'(exp));
        @(negedge clk);
        check(pass == good, "R8 hold", int'(pass), int'(good));
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(signature == 0, "R1 signature", int'(signature), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(pass == 1'b0, "R1 pass", int'(pass), 0);
        resp_valid = 1'b1; resp_data = 8'h3C;
        @(negedge clk);
        resp_valid = 1'b0;
        check(signature == 0, "R7 idle ignore", int'(signature), 0);
        run(2'd0, 0, 1'b1, 1'b0);
        run(2'd1, 0, 1'b0, 1'b0);
        run(2'd2, 0, 1'b1, 1'b0);
        run(2'd3, 0, 1'b0, 1'b0);
        run(2'd0, 1, 1'b1, 1'b0);
        run(2'd1, 2, 1'b1, 1'b0);
        run(2'd1, 3, 1'b1, 1'b0);
        run(2'd2, 1, 1'b0, 1'b0);
        run(2'd0, 0, 1'b1, 1'b1);
        run(2'd2, 0, 1'b1, 1'b1);
        for (int k = 0; k < 6; k++) begin
            run(2'($urandom % 4), int'($urandom % 4), 1'($urandom % 2), 1'b0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule